// File: doc/BRIEF.md
# Synchronous Trap Entry Sequencer

This block performs the state changes a processor core needs when it enters a trap handler. A trap request brings a 3-bit trap class and an 8-bit trap identification code. The block takes a snapshot of the core state at that moment: the program counter, status word, previous-context pointer, interrupt control word, interrupt stack pointer, current stack pointer, trap vector base and the fault PC used for free-list depletion. From this snapshot it builds the handler-entry values.

Most traps first need the upper register context saved. The block asks for this save through a request/acknowledge handshake with an external save engine. It does not apply the new state until that save is acknowledged. One case cannot be saved at all: the free-list-empty trap of the context-management class. For that case the block skips the save and applies the new state immediately.

Each completed entry produces a one-cycle `done` pulse, together with registered values for:
- the new PC, status word and stack pointer,
- the return-address register,
- data register 15,
- the previous-context pointer,
- a pulse that sets the fault flag in the system configuration word.

Top module: `trap_entry_seq`

## Requirements
- R1: On every completed entry, `new_d15` equals the trap identification code, zero-extended to 32 bits.
- R2: An upper-context save is requested (`save_req` high) for every trap except class 3 with code 4. That case raises `done` in the cycle after the request and never raises `save_req`.
- R3: `new_ra` selection:
  - Class 3 with code 1: `new_ra` takes the supplied fault PC and `fcd_flag_set` pulses together with `done`.
  - Class 6: `new_ra` is PC+4, modulo 2^32.
  - Any other trap: `new_ra` is PC.
  - `fcd_flag_set` is low for every trap other than class 3 with code 1.
- R4: If status bit 9 (interrupt-stack in use) was 0, `new_sp` takes the interrupt stack pointer. Otherwise `new_sp` keeps the current stack pointer.
- R5: In `new_psw`, bit 9 is 1 and bits 11:10 are binary 10 (supervisor I/O privilege).
- R6: In `new_psw`, the following fields are set, and bits 31:14 are copied unchanged:
  - bits 13:12 (protection set) are 0,
  - bits 6:0 (call depth counter) are 0,
  - bit 7 (call depth enable) is 1,
  - bit 8 (global register write) is 0.
- R7: In `new_pcxi`, bits 31:24 take interrupt control bits 7:0 (current priority), bit 23 takes interrupt control bit 8 (interrupt enable), and bits 22:0 are kept.
- R8: `new_pc` equals the vector base OR (class shifted left by 5).
- R9: While a save is pending, `save_req` stays high. `done` rises in the cycle after the edge at which `save_ack` is sampled high, and it lasts one cycle.
- R10: `busy` is high from the request until the save is acknowledged. Trap requests that arrive while busy are ignored, and the outputs remain those of the first request.
- R11: A synchronous active-low reset clears every output to 0 and abandons any pending save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Trap request, sampled when not busy |
| trap_class | input | 3 | Trap class |
| trap_tin | input | 8 | Trap identification code |
| cur_pc | input | 32 | PC of the trapping instruction |
| cur_psw | input | 32 | Current status word |
| cur_pcxi | input | 32 | Current previous-context pointer |
| cur_icr | input | 32 | Interrupt control word (bits 7:0 priority, bit 8 enable) |
| cur_isp | input | 32 | Interrupt stack pointer |
| cur_sp | input | 32 | Current stack pointer |
| cur_btv | input | 32 | Trap vector base |
| fcd_pc | input | 32 | Return address used for free-list depletion |
| save_ack | input | 1 | Save engine acknowledge |
| save_req | output | 1 | Upper-context save request |
| busy | output | 1 | Entry in progress, requests ignored |
| done | output | 1 | One-cycle entry-complete pulse |
| new_pc | output | 32 | Handler address |
| new_psw | output | 32 | Status word after entry |
| new_sp | output | 32 | Stack pointer after entry |
| new_ra | output | 32 | Return address after entry |
| new_d15 | output | 32 | Data register 15 after entry |
| new_pcxi | output | 32 | Previous-context pointer after entry |
| fcd_flag_set | output | 1 | Pulse that sets the depletion flag in system config |

## Verification
The vector table mixes the three return-address cases:
- the fault-PC code,
- syscall traps, including one whose PC wraps past 2^32,
- plain traps, including a code 4 outside the context class, which must still request a save.

Status words with the interrupt-stack bit clear and set separate the two stack-pointer choices. An all-ones status word shows which bits are forced and which are copied. Vector bases with low bits that overlap the shifted class confirm an OR rather than an add. Acknowledge delays of zero to three cycles, with conflicting requests and altered core state driven during the wait, show that the first snapshot is kept and the second request is dropped.

// File: rtl/trap_entry_pkg.sv
// Package: shared widths, field positions, trap codes and types for the
// trap entry sequencer. Field positions are fixed by the status-word and
// context-pointer layout consumed by the rest of the core.
package trap_entry_pkg;

    parameter int XLEN      = 32;
    parameter int CLS_W     = 3;
    parameter int TIN_W     = 8;
    parameter int VEC_SHIFT = 5;

    // Status word layout
    parameter int PSW_CDC_LSB = 0;
    parameter int PSW_CDC_W   = 7;
    parameter int PSW_CDE_BIT = 7;
    parameter int PSW_GW_BIT  = 8;
    parameter int PSW_IS_BIT  = 9;
    parameter int PSW_IO_LSB  = 10;
    parameter int PSW_IO_W    = 2;
    parameter int PSW_PRS_LSB = 12;
    parameter int PSW_PRS_W   = 2;
    parameter logic [PSW_IO_W-1:0] IO_SUPERVISOR = 2'b10;

    // Interrupt control and context pointer layout
    parameter int ICR_PRIO_LSB   = 0;
    parameter int ICR_PRIO_W     = 8;
    parameter int ICR_IE_BIT     = 8;
    parameter int PCXI_PIE_BIT   = 23;
    parameter int PCXI_PRIO_LSB  = 24;

    // Trap classes and codes with special handling
    parameter logic [CLS_W-1:0] CLS_CTX_MGMT  = 3'd3;
    parameter logic [CLS_W-1:0] CLS_SYSCALL   = 3'd6;
    parameter logic [TIN_W-1:0] TIN_FREE_LAST = 8'd1;
    parameter logic [TIN_W-1:0] TIN_FREE_NONE = 8'd4;

    localparam int RA_STEP = 4;

    // Snapshot of everything the entry computation depends on
    typedef struct packed {
        logic [CLS_W-1:0] cls;
        logic [TIN_W-1:0] tin;
        logic [XLEN-1:0]  pc;
        logic [XLEN-1:0]  psw;
        logic [XLEN-1:0]  pcxi;
        logic [XLEN-1:0]  icr;
        logic [XLEN-1:0]  isp;
        logic [XLEN-1:0]  sp;
        logic [XLEN-1:0]  btv;
        logic [XLEN-1:0]  fcd_pc;
    } trap_snap_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SAVE = 1'b1
    } seq_state_t;

endpackage

// File: rtl/trap_status_builder.sv
// Module: trap_status_builder
// Builds the handler-entry status word field by field and selects the
// stack pointer from the interrupt-stack bit of the incoming status word.
// Assumes the field layout given in trap_entry_pkg. Purely combinational.
module trap_status_builder
    import trap_entry_pkg::*;
(
    input  trap_snap_t       snap,
    output logic [XLEN-1:0]  psw_out,
    output logic [XLEN-1:0]  sp_out
);

    // Force supervisor entry fields, keep all other bits
    always_comb begin
        psw_out = snap.psw;
        psw_out[PSW_IS_BIT] = 1'b1;
        psw_out[PSW_IO_LSB +: PSW_IO_W] = IO_SUPERVISOR;
        psw_out[PSW_PRS_LSB +: PSW_PRS_W] = '0;
        psw_out[PSW_CDC_LSB +: PSW_CDC_W] = '0;
        psw_out[PSW_CDE_BIT] = 1'b1;
        psw_out[PSW_GW_BIT] = 1'b0;
    end

    // Switch to the interrupt stack only if it was not already in use
    always_comb begin
        sp_out = snap.psw[PSW_IS_BIT] ? snap.sp : snap.isp;
    end

endmodule

// File: rtl/trap_link_calc.sv
// Module: trap_link_calc
// Decides whether an upper-context save is needed, chooses the return
// address by trap kind, forms the vector address and the D15 value.
// Assumes class/code constants from trap_entry_pkg. Purely combinational.
module trap_link_calc
    import trap_entry_pkg::*;
(
    input  trap_snap_t       snap,
    output logic             save_needed,
    output logic             fcd_hit,
    output logic [XLEN-1:0]  ra_out,
    output logic [XLEN-1:0]  vec_out,
    output logic [XLEN-1:0]  d15_out
);

    logic is_ctx;

    // Identify the special trap kinds
    always_comb begin
        is_ctx      = (snap.cls == CLS_CTX_MGMT);
        save_needed = !(is_ctx && (snap.tin == TIN_FREE_NONE));
        fcd_hit     = is_ctx && (snap.tin == TIN_FREE_LAST);
    end

    // Return address selection, depletion case has priority over syscall
    always_comb begin
        if (fcd_hit) begin
            ra_out = snap.fcd_pc;
        end else if (snap.cls == CLS_SYSCALL) begin
            ra_out = snap.pc + XLEN'(RA_STEP);
        end else begin
            ra_out = snap.pc;
        end
    end

    // Handler vector and trap code register value
    always_comb begin
        vec_out = snap.btv | (XLEN'(snap.cls) << VEC_SHIFT);
        d15_out = XLEN'(snap.tin);
    end

endmodule

// File: rtl/trap_ctxptr_update.sv
// Module: trap_ctxptr_update
// Copies the interrupt enable and current priority from the interrupt
// control word into the previous-context pointer; other bits are kept.
// Assumes PCXI_PRIO field reaches the top bit. Purely combinational.
module trap_ctxptr_update
    import trap_entry_pkg::*;
(
    input  trap_snap_t       snap,
    output logic [XLEN-1:0]  pcxi_out
);

    // Save old enable and priority into the context pointer
    always_comb begin
        pcxi_out = snap.pcxi;
        pcxi_out[PCXI_PIE_BIT] = snap.icr[ICR_IE_BIT];
        pcxi_out[PCXI_PRIO_LSB +: ICR_PRIO_W] = snap.icr[ICR_PRIO_LSB +: ICR_PRIO_W];
    end

endmodule

// File: rtl/trap_entry_seq.sv
// Module: trap_entry_seq (top)
// Accepts a trap request when idle, snapshots the core state, requests an
// upper-context save when one is allowed, and loads the handler-entry
// state either at the request edge (no save) or at the edge that samples
// the save acknowledge. Assumes save_ack is only meaningful while save_req
// is high. Synchronous active-low reset.
module trap_entry_seq
    import trap_entry_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trap_req,
    input  logic [2:0]       trap_class,
    input  logic [7:0]       trap_tin,
    input  logic [31:0]      cur_pc,
    input  logic [31:0]      cur_psw,
    input  logic [31:0]      cur_pcxi,
    input  logic [31:0]      cur_icr,
    input  logic [31:0]      cur_isp,
    input  logic [31:0]      cur_sp,
    input  logic [31:0]      cur_btv,
    input  logic [31:0]      fcd_pc,
    input  logic             save_ack,
    output logic             save_req,
    output logic             busy,
    output logic             done,
    output logic [31:0]      new_pc,
    output logic [31:0]      new_psw,
    output logic [31:0]      new_sp,
    output logic [31:0]      new_ra,
    output logic [31:0]      new_d15,
    output logic [31:0]      new_pcxi,
    output logic             fcd_flag_set
);

    seq_state_t       state_q;
    trap_snap_t       live_snap;
    trap_snap_t       held_snap;
    trap_snap_t       work_snap;
    logic             accept;
    logic             finish;
    logic             save_needed;
    logic             fcd_hit;
    logic [XLEN-1:0]  psw_c, sp_c, ra_c, vec_c, d15_c, pcxi_c;

    // Gather the live inputs into one snapshot
    always_comb begin
        live_snap.cls    = trap_class;
        live_snap.tin    = trap_tin;
        live_snap.pc     = cur_pc;
        live_snap.psw    = cur_psw;
        live_snap.pcxi   = cur_pcxi;
        live_snap.icr    = cur_icr;
        live_snap.isp    = cur_isp;
        live_snap.sp     = cur_sp;
        live_snap.btv    = cur_btv;
        live_snap.fcd_pc = fcd_pc;
    end

    // Use live inputs at acceptance, the held snapshot while saving
    always_comb begin
        work_snap = (state_q == ST_IDLE) ? live_snap : held_snap;
    end

    trap_status_builder u_status (
        .snap    (work_snap),
        .psw_out (psw_c),
        .sp_out  (sp_c)
    );

    trap_link_calc u_link (
        .snap        (work_snap),
        .save_needed (save_needed),
        .fcd_hit     (fcd_hit),
        .ra_out      (ra_c),
        .vec_out     (vec_c),
        .d15_out     (d15_c)
    );

    trap_ctxptr_update u_ctxptr (
        .snap     (work_snap),
        .pcxi_out (pcxi_c)
    );

    // Acceptance and completion conditions
    always_comb begin
        accept = trap_req && (state_q == ST_IDLE);
        finish = (accept && !save_needed) || ((state_q == ST_SAVE) && save_ack);
    end

    // Handshake and busy indication
    always_comb begin
        save_req = (state_q == ST_SAVE);
        busy     = (state_q == ST_SAVE);
    end

    // Sequencer state and request snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            held_snap <= '0;
        end else begin
            if (accept) begin
                held_snap <= live_snap;
                if (save_needed) begin
                    state_q <= ST_SAVE;
                end
            end else if ((state_q == ST_SAVE) && save_ack) begin
                state_q <= ST_IDLE;
            end
        end
    end

    // Load the handler-entry state and the completion pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_pc       <= '0;
            new_psw      <= '0;
            new_sp       <= '0;
            new_ra       <= '0;
            new_d15      <= '0;
            new_pcxi     <= '0;
            done         <= 1'b0;
            fcd_flag_set <= 1'b0;
        end else begin
            done         <= finish;
            fcd_flag_set <= finish && fcd_hit;
            if (finish) begin
                new_pc   <= vec_c;
                new_psw  <= psw_c;
                new_sp   <= sp_c;
                new_ra   <= ra_c;
                new_d15  <= d15_c;
                new_pcxi <= pcxi_c;
            end
        end
    end

endmodule

// File: rtl/trap_entry_checker.sv
// Module: trap_entry_checker
// Temporal properties of the trap entry sequencer, observed at its ports.
// Bound into every trap_entry_seq instance below.
module trap_entry_checker
    import trap_entry_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        save_req,
    input logic        save_ack,
    input logic        busy,
    input logic        done,
    input logic        fcd_flag_set,
    input logic [31:0] new_pc,
    input logic [31:0] new_psw,
    input logic [31:0] new_d15
);

    assert_d15_zero_ext_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (new_d15[XLEN-1:TIN_W] == '0));

    assert_req_persist_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !save_ack) |=> save_req);

    assert_fcd_with_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fcd_flag_set |-> done);

    assert_stack_priv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (new_psw[PSW_IS_BIT] && (new_psw[PSW_IO_LSB +: PSW_IO_W] == IO_SUPERVISOR)));

    assert_fields_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (new_psw[PSW_CDE_BIT] && !new_psw[PSW_GW_BIT]
                  && (new_psw[PSW_CDC_LSB +: PSW_CDC_W] == '0)
                  && (new_psw[PSW_PRS_LSB +: PSW_PRS_W] == '0)));

    assert_ack_completes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && save_ack) |=> done);

    assert_wait_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !save_ack) |=> (!done && $stable(new_pc) && $stable(new_psw)));

    assert_idle_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && save_ack) |=> !busy);

endmodule

bind trap_entry_seq trap_entry_checker u_trap_entry_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .save_req     (save_req),
    .save_ack     (save_ack),
    .busy         (busy),
    .done         (done),
    .fcd_flag_set (fcd_flag_set),
    .new_pc       (new_pc),
    .new_psw      (new_psw),
    .new_d15      (new_d15)
);

// File: tb/trap_entry_seq_test.sv
`timescale 1ns/1ps
// Bench for trap_entry_seq: table-driven traps, then directed cases.
module trap_entry_seq_test;

    typedef struct packed {
        logic [2:0]  cls;
        logic [7:0]  tin;
        logic [31:0] pc;
        logic [31:0] psw;
        logic [31:0] pcxi;
        logic [31:0] icr;
        logic [31:0] isp;
        logic [31:0] sp;
        logic [31:0] btv;
        logic [31:0] fpc;
        logic [3:0]  dly;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{3'd3, 8'd4,   32'h0000_1000, 32'h0000_0000, 32'h1234_5678, 32'h0000_01A5, 32'h7000_0000, 32'h6000_0000, 32'h8000_0000, 32'hDEAD_0000, 4'd0},
        '{3'd3, 8'd1,   32'h0000_2000, 32'h0000_0200, 32'hFFFF_FFFF, 32'h0000_0033, 32'h7000_0100, 32'h6000_0100, 32'h8000_0100, 32'hCAFE_0010, 4'd2},
        '{3'd6, 8'd0,   32'h0000_3000, 32'h0000_0000, 32'h0000_0000, 32'h0000_01FF, 32'h7000_0200, 32'h6000_0200, 32'h8000_0200, 32'hBEEF_0000, 4'd0},
        '{3'd1, 8'd2,   32'h0000_4004, 32'hFFFF_FFFF, 32'h00AA_AAAA, 32'h0000_0100, 32'h7000_0300, 32'h6000_0300, 32'h8000_0000, 32'h1111_1111, 4'd3},
        '{3'd3, 8'd2,   32'h0000_5008, 32'hA5A5_5A5A, 32'h5500_FF00, 32'h0000_0080, 32'h7000_0400, 32'h6000_0400, 32'h9000_0000, 32'h2222_2222, 4'd1},
        '{3'd7, 8'd255, 32'h0000_6000, 32'h0000_0155, 32'h0080_0001, 32'h0000_0000, 32'h7000_0500, 32'h6000_0500, 32'h8000_00FF, 32'h3333_3333, 4'd0},
        '{3'd6, 8'd1,   32'hFFFF_FFFC, 32'h0000_3DFF, 32'h7F7F_7F7F, 32'h0000_0101, 32'h7000_0600, 32'h6000_0600, 32'hA000_0000, 32'h4444_4444, 4'd1},
        '{3'd0, 8'd4,   32'h0000_8000, 32'hFFFF_FDFF, 32'h0100_0000, 32'h0000_01C3, 32'h7000_0700, 32'h6000_0700, 32'hB000_0000, 32'h5555_5555, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trap_req = 1'b0;
    logic [2:0]  trap_class = '0;
    logic [7:0]  trap_tin = '0;
    logic [31:0] cur_pc = '0, cur_psw = '0, cur_pcxi = '0, cur_icr = '0;
    logic [31:0] cur_isp = '0, cur_sp = '0, cur_btv = '0, fcd_pc = '0;
    logic        save_ack = 1'b0;
    logic        save_req, busy, done, fcd_flag_set;
    logic [31:0] new_pc, new_psw, new_sp, new_ra, new_d15, new_pcxi;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    trap_entry_seq uut (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_class(trap_class),
        .trap_tin(trap_tin), .cur_pc(cur_pc), .cur_psw(cur_psw), .cur_pcxi(cur_pcxi),
        .cur_icr(cur_icr), .cur_isp(cur_isp), .cur_sp(cur_sp), .cur_btv(cur_btv),
        .fcd_pc(fcd_pc), .save_ack(save_ack), .save_req(save_req), .busy(busy),
        .done(done), .new_pc(new_pc), .new_psw(new_psw), .new_sp(new_sp),
        .new_ra(new_ra), .new_d15(new_d15), .new_pcxi(new_pcxi),
        .fcd_flag_set(fcd_flag_set)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        trap_class = v.cls;  trap_tin = v.tin;  cur_pc = v.pc;
        cur_psw = v.psw;     cur_pcxi = v.pcxi; cur_icr = v.icr;
        cur_isp = v.isp;     cur_sp = v.sp;     cur_btv = v.btv;
        fcd_pc = v.fpc;
    endtask

    // Check all entry outputs against values derived from the requirements
    task automatic check_entry(input vec_t v);
        logic [31:0] exp_ra;
        logic        is_fcd;
        is_fcd = (v.cls == 3'd3) && (v.tin == 8'd1);
        if (is_fcd)              exp_ra = v.fpc;
        else if (v.cls == 3'd6)  exp_ra = v.pc + 32'd4;
        else                     exp_ra = v.pc;
        chk("R1", "new_d15", new_d15, {24'h0, v.tin});
        chk("R3", "new_ra", new_ra, exp_ra);
        chk("R3", "fcd_flag_set", {31'h0, fcd_flag_set}, {31'h0, is_fcd});
        chk("R4", "new_sp", new_sp, v.psw[9] ? v.sp : v.isp);
        chk("R5", "new_psw[11:9]", {29'h0, new_psw[11:9]}, 32'd5);
        chk("R6", "new_psw", new_psw, (v.psw & 32'hFFFF_C000) | 32'h0000_0A80);
        chk("R7", "new_pcxi", new_pcxi, {v.icr[7:0], v.icr[8], v.pcxi[22:0]});
        chk("R8", "new_pc", new_pc, v.btv | ({29'h0, v.cls} << 5));
    endtask

    task automatic run_vec(input vec_t v);
        bit needs_save;
        needs_save = !((v.cls == 3'd3) && (v.tin == 8'd4));
        @(negedge clk);
        drive(v);
        trap_req = 1'b1;
        save_ack = 1'b0;
        @(negedge clk);
        if (!needs_save) begin
            trap_req = 1'b0;
            chk("R2", "done (no save)", {31'h0, done}, 32'd1);
            chk("R2", "save_req (no save)", {31'h0, save_req}, 32'd0);
        end else begin
            chk("R2", "save_req", {31'h0, save_req}, 32'd1);
            chk("R10", "busy", {31'h0, busy}, 32'd1);
            chk("R9", "done before ack", {31'h0, done}, 32'd0);
            // competing request with altered state while busy
            trap_class = ~v.cls; trap_tin = ~v.tin; cur_pc = ~v.pc;
            cur_psw = ~v.psw; cur_btv = ~v.btv; cur_icr = ~v.icr; fcd_pc = ~v.fpc;
            for (int k = 0; k < int'(v.dly); k++) begin
                @(negedge clk);
                chk("R9", "save_req held", {31'h0, save_req}, 32'd1);
                chk("R10", "done while busy", {31'h0, done}, 32'd0);
            end
            save_ack = 1'b1;
            @(negedge clk);
            save_ack = 1'b0;
            trap_req = 1'b0;
            chk("R9", "done after ack", {31'h0, done}, 32'd1);
            chk("R10", "busy after ack", {31'h0, busy}, 32'd0);
        end
        check_entry(v);
        @(negedge clk);
        chk("R9", "done one cycle", {31'h0, done}, 32'd0);
        chk("R10", "no extra entry", {31'h0, save_req}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11", "reset done", {31'h0, done}, 32'd0);
        chk("R11", "reset busy", {31'h0, busy}, 32'd0);
        chk("R11", "reset save_req", {31'h0, save_req}, 32'd0);
        chk("R11", "reset new_pc", new_pc, 32'd0);
        chk("R11", "reset new_psw", new_psw, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VECS[i]);
        end

        // Back-to-back unsaved entries on consecutive cycles (R2)
        @(negedge clk);
        drive(VECS[0]);
        trap_req = 1'b1;
        @(negedge clk);
        chk("R2", "b2b first done", {31'h0, done}, 32'd1);
        check_entry(VECS[0]);
        cur_btv = 32'h4000_0000;
        @(negedge clk);
        trap_req = 1'b0;
        chk("R2", "b2b second done", {31'h0, done}, 32'd1);
        chk("R8", "b2b second pc", new_pc, 32'h4000_0060);

        // Reset while a save is pending (R11)
        @(negedge clk);
        drive(VECS[3]);
        trap_req = 1'b1;
        @(negedge clk);
        trap_req = 1'b0;
        chk("R10", "busy before reset", {31'h0, busy}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11", "reset abandons save", {31'h0, save_req}, 32'd0);
        chk("R11", "reset clears new_ra", new_ra, 32'd0);
        chk("R11", "reset clears new_pcxi", new_pcxi, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11", "idle after reset", {31'h0, busy}, 32'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL R9 watchdog: actual=hung expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule